// File: doc/BRIEF.md
# Lossy Fast Channel Register Bank

This block is a bank of word-wide value registers for passing data one way with very little overhead. A sender writes a word into any channel at any time. There is no handshake and nothing holds a write back, so a new word always replaces the one before it, even if the receiver never saw the older word. The receiver reads any channel and gets the most recent word stored there.

Every accepted write also sets a sticky per-channel event flag. The receiver clears these flags by writing ones to their positions. The flags, ANDed with a per-channel mask, are ORed into a single receiver interrupt. When a write lands on a channel whose event is still pending, a per-channel overrun flag is set. This lets the receiver detect that at least one value was replaced before it was serviced.

A read-only capability word reports the channel count and the data width, so software can find the bank's size at run time.

Top module: `fch_bank`

## Requirements
- R1: After reset, every channel word, event flag, overrun flag and mask bit is 0, `irq_o` is 0 and `rd_valid_o` is 0.
- R2: A read request on `rd_ch_i` yields, on the next cycle, `rd_valid_o`=1 with `rd_data_o` equal to the last word written to that channel. A later write always replaces an older word.
- R3: If a read and a write address the same channel in the same cycle, the read returns the word held before that write.
- R4: A write to channel k sets event flag k on the next cycle. The flag stays set until the receiver clears it.
- R5: A 1 in bit k of `evt_clr_i` clears event flag k on the next cycle. If a write to channel k happens in the same cycle, the flag stays set.
- R6: A write to channel k while event flag k is set, and not cleared in that cycle, sets overrun flag k on the next cycle. A write while the flag is clear, or while it is cleared in that cycle, leaves the overrun flag unchanged.
- R7: A 1 in bit k of `ovr_clr_i` clears overrun flag k. A new overrun on channel k in the same cycle takes priority, and the flag stays set.
- R8: `mask_o` loads `mask_i` when `mask_we_i` is 1. `irq_o` is 1 exactly when some channel has both its event flag and its mask bit set.
- R9: `cap_o` reports the channel count in bits [15:0] and the data width in bits [31:16].
- R10: A write to a channel index at or above the channel count is ignored: no word, event or overrun flag changes. A read of such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Sender write strobe |
| wr_ch_i | input | CH_W | Sender channel index |
| wr_data_i | input | DW | Sender word |
| rd_en_i | input | 1 | Receiver read strobe |
| rd_ch_i | input | CH_W | Receiver channel index |
| rd_data_o | output | DW | Read word, one cycle after request |
| rd_valid_o | output | 1 | Read word valid |
| evt_clr_i | input | N_CH | Write-one-to-clear for event flags |
| ovr_clr_i | input | N_CH | Write-one-to-clear for overrun flags |
| mask_we_i | input | 1 | Mask load strobe |
| mask_i | input | N_CH | New mask value |
| mask_o | output | N_CH | Current interrupt mask |
| evt_o | output | N_CH | Pending event flags |
| ovr_o | output | N_CH | Overrun flags |
| irq_o | output | 1 | Receiver interrupt |
| cap_o | output | 32 | Capability word |

## Verification
The hardest situations to reach are the same-cycle collisions: a read meeting a write on one channel, a write meeting an event clear, and a new overrun meeting an overrun clear. Each one needs two independent port groups to line up on the same channel in one cycle. The driver task applies both stimuli in a single step, and a cycle-accurate model predicts the result. The default configuration has six channels and a three-bit index, so indices 6 and 7 can be driven to exercise the out-of-range path.

// File: rtl/fch_pkg.sv
package fch_pkg;
  localparam int CAP_W = 32;

  function automatic logic [CAP_W-1:0] cap_word(input int n_ch, input int dw);
    logic [15:0] n16, w16;
    n16 = 16'(n_ch);
    w16 = 16'(dw);
    return {w16, n16};
  endfunction
endpackage

// File: rtl/fch_store.sv
module fch_store #(
  parameter int N_CH = 6,
  parameter int DW   = 32,
  parameter int CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] wr_hit_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            rd_en_i,
  input  logic [CH_W-1:0] rd_ch_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_valid_o
);
  logic [DW-1:0] mem_q [N_CH];
  logic [DW-1:0] rd_sel;
  logic          rd_in_range;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          mem_q[i] <= '0;
      else if (wr_hit_i[i]) mem_q[i] <= wr_data_i;
    end
  end

  // pre-write value is sampled, so a colliding write is not seen
  always_comb begin
    rd_sel      = '0;
    rd_in_range = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (rd_ch_i == CH_W'(i)) begin
        rd_sel      = mem_q[i];
        rd_in_range = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_sel;
    end
  end

  assert_rd_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  assert_rd_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  assert_rd_oob_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_in_range) |=> (rd_data_o == '0));
endmodule

// File: rtl/fch_evt.sv
module fch_evt #(
  parameter int N_CH = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] set_i,
  input  logic [N_CH-1:0] evt_clr_i,
  input  logic [N_CH-1:0] ovr_clr_i,
  output logic [N_CH-1:0] evt_o,
  output logic [N_CH-1:0] ovr_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_flag
    logic ovr_hit;
    // an event cleared in the same cycle counts as serviced
    assign ovr_hit = set_i[i] & evt_o[i] & ~evt_clr_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        evt_o[i] <= 1'b0;
        ovr_o[i] <= 1'b0;
      end else begin
        if (set_i[i])          evt_o[i] <= 1'b1;
        else if (evt_clr_i[i]) evt_o[i] <= 1'b0;
        if (ovr_hit)           ovr_o[i] <= 1'b1;
        else if (ovr_clr_i[i]) ovr_o[i] <= 1'b0;
      end
    end

    assert_evt_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> evt_o[i]);
    assert_evt_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_clr_i[i] && !set_i[i]) |=> !evt_o[i]);
    assert_ovr_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovr_o[i]) |-> ($past(evt_o[i]) && $past(set_i[i])));
    assert_ovr_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovr_clr_i[i] && !set_i[i]) |=> !ovr_o[i]);
  end
endmodule

// File: rtl/fch_irq.sv
module fch_irq #(
  parameter int N_CH = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mask_we_i,
  input  logic [N_CH-1:0] mask_i,
  input  logic [N_CH-1:0] evt_i,
  output logic [N_CH-1:0] mask_o,
  output logic            irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '0;
    else if (mask_we_i) mask_o <= mask_i;
  end

  assign irq_o = |(evt_i & mask_o);

  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '0) |-> !irq_o);
  assert_mask_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_o == $past(mask_i)));
  assert_no_evt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0) |-> !irq_o);
endmodule

// File: rtl/fch_bank.sv
module fch_bank
  import fch_pkg::*;
#(
  parameter int N_CH = 6,
  parameter int DW   = 32,
  parameter int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  input  logic [N_CH-1:0]  evt_clr_i,
  input  logic [N_CH-1:0]  ovr_clr_i,
  input  logic             mask_we_i,
  input  logic [N_CH-1:0]  mask_i,
  output logic [N_CH-1:0]  mask_o,
  output logic [N_CH-1:0]  evt_o,
  output logic [N_CH-1:0]  ovr_o,
  output logic             irq_o,
  output logic [CAP_W-1:0] cap_o
);
  logic [N_CH-1:0] wr_hit;

  always_comb begin
    wr_hit = '0;
    for (int i = 0; i < N_CH; i++)
      wr_hit[i] = wr_en_i && (wr_ch_i == CH_W'(i));
  end

  assign cap_o = cap_word(N_CH, DW);

  fch_store #(.N_CH(N_CH), .DW(DW), .CH_W(CH_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_hit_i   (wr_hit),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rd_ch_i    (rd_ch_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  fch_evt #(.N_CH(N_CH)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (wr_hit),
    .evt_clr_i (evt_clr_i),
    .ovr_clr_i (ovr_clr_i),
    .evt_o     (evt_o),
    .ovr_o     (ovr_o)
  );

  fch_irq #(.N_CH(N_CH)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (mask_we_i),
    .mask_i    (mask_i),
    .evt_i     (evt_o),
    .mask_o    (mask_o),
    .irq_o     (irq_o)
  );

  assert_one_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit));
  assert_idle_evt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && evt_clr_i == '0) |=> $stable(evt_o));
endmodule

// File: tb/fch_bank_bench.sv
`timescale 1ns/1ps
module fch_bank_bench;
  localparam int N_CH = 6;
  localparam int DW   = 32;
  localparam int CH_W = 3;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_en_i = 1'b0;
  logic [CH_W-1:0] wr_ch_i = '0;
  logic [DW-1:0]   wr_data_i = '0;
  logic            rd_en_i = 1'b0;
  logic [CH_W-1:0] rd_ch_i = '0;
  logic [DW-1:0]   rd_data_o;
  logic            rd_valid_o;
  logic [N_CH-1:0] evt_clr_i = '0;
  logic [N_CH-1:0] ovr_clr_i = '0;
  logic            mask_we_i = 1'b0;
  logic [N_CH-1:0] mask_i = '0;
  logic [N_CH-1:0] mask_o, evt_o, ovr_o;
  logic            irq_o;
  logic [31:0]     cap_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0]   mem_m [N_CH];
  logic [N_CH-1:0] evt_m = '0, ovr_m = '0, mask_m = '0;
  logic [DW-1:0]   exp_q [$];
  string           tag_q [$];

  always #4 clk_i = ~clk_i;

  fch_bank #(.N_CH(N_CH), .DW(DW), .CH_W(CH_W)) u_fch_bank (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read words as the design returns them
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) chk("R2 unexpected read", 64'(rd_valid_o), 64'd0);
      else chk(tag_q.pop_front(), 64'(rd_data_o), 64'(exp_q.pop_front()));
    end
  end

  // driver: one cycle of stimulus, model update, then flag checks
  task automatic step(input string tag,
                      input bit we, input int wch, input logic [DW-1:0] wd,
                      input bit re, input int rch,
                      input logic [N_CH-1:0] eclr, input logic [N_CH-1:0] oclr,
                      input bit mwe, input logic [N_CH-1:0] mval);
    logic [N_CH-1:0] ne, no;
    wr_en_i = we; wr_ch_i = CH_W'(wch); wr_data_i = wd;
    rd_en_i = re; rd_ch_i = CH_W'(rch);
    evt_clr_i = eclr; ovr_clr_i = oclr; mask_we_i = mwe; mask_i = mval;
    if (re) begin
      exp_q.push_back((rch < N_CH) ? mem_m[rch] : '0);
      tag_q.push_back(tag);
    end
    ne = evt_m & ~eclr;
    no = ovr_m & ~oclr;
    if (we && wch < N_CH) begin
      ne[wch] = 1'b1;
      if (evt_m[wch] && !eclr[wch]) no[wch] = 1'b1;
      mem_m[wch] = wd;
    end
    evt_m = ne; ovr_m = no;
    if (mwe) mask_m = mval;
    @(negedge clk_i);
    wr_en_i = 0; rd_en_i = 0; evt_clr_i = '0; ovr_clr_i = '0; mask_we_i = 0;
    chk({tag, " evt"}, 64'(evt_o), 64'(evt_m));
    chk({tag, " ovr"}, 64'(ovr_o), 64'(ovr_m));
    chk({tag, " mask"}, 64'(mask_o), 64'(mask_m));
    chk({tag, " irq"}, 64'(irq_o), 64'(|(evt_m & mask_m)));
  endtask

  initial begin
    #(8ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N_CH; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 evt", 64'(evt_o), 0);
    chk("R1 ovr", 64'(ovr_o), 0);
    chk("R1 irq", 64'(irq_o), 0);
    chk("R1 rd_valid", 64'(rd_valid_o), 0);
    chk("R1 mask", 64'(mask_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 capability
    chk("R9 cap", 64'(cap_o), 64'({16'd32, 16'd6}));
    step("R1 read zero", 0, 0, 0, 1, 0, '0, '0, 0, '0);
    step("R4 first write", 1, 2, 32'hA5A5_0001, 0, 0, '0, '0, 0, '0);
    step("R2 read back", 0, 0, 0, 1, 2, '0, '0, 0, '0);
    step("R6 overwrite pending", 1, 2, 32'h0000_1234, 0, 0, '0, '0, 0, '0);
    step("R2 overwrite read", 0, 0, 0, 1, 2, '0, '0, 0, '0);
    step("R3 collide", 1, 3, 32'hDEAD_BEEF, 1, 3, '0, '0, 0, '0);
    step("R3 after collide", 0, 0, 0, 1, 3, '0, '0, 0, '0);
    step("R5 clear", 0, 0, 0, 0, 0, 6'b000100, '0, 0, '0);
    step("R7 clear ovr", 0, 0, 0, 0, 0, '0, 6'b000100, 0, '0);
    step("R5 write beats clear", 1, 1, 32'h11, 0, 0, 6'b000010, '0, 0, '0);
    step("R6 cleared write no ovr", 1, 1, 32'h22, 0, 0, 6'b000010, '0, 0, '0);
    step("R8 mask ch4", 0, 0, 0, 0, 0, '0, '0, 1, 6'b010000);
    step("R8 irq on ch4", 1, 4, 32'h44, 0, 0, '0, '0, 0, '0);
    step("R8 clear ch4", 0, 0, 0, 0, 0, 6'b010000, '0, 0, '0);
    step("R8 mask ch1", 0, 0, 0, 0, 0, '0, '0, 1, 6'b000010);
    step("R10 oob write", 1, 7, 32'hFFFF_FFFF, 0, 0, '0, '0, 0, '0);
    step("R10 oob write6", 1, 6, 32'h6666_6666, 0, 0, '0, '0, 0, '0);
    step("R10 oob read", 0, 0, 0, 1, 7, '0, '0, 0, '0);
    step("R10 ch0 intact", 0, 0, 0, 1, 0, '0, '0, 0, '0);
    step("R7 ovr beats clear", 1, 1, 32'h33, 0, 0, '0, 6'b000010, 0, '0);
    step("R2 last word ch1", 0, 0, 0, 1, 1, '0, '0, 0, '0);
    step("R8 idle", 0, 0, 0, 0, 0, 6'b111111, 6'b111111, 0, '0);
    @(negedge clk_i);
    chk("R2 queue drained", 64'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule